// File: doc/BRIEF.md
# Flag-Setting Data-Processing ALU

This block is the arithmetic and logic stage of a processor's data-processing path. In one cycle it takes an operation code, a first operand read from a register, and a second operand that the shifter has already prepared. It also takes the shifter's carry-out, two multiplier sources and the current condition flags. From these it produces a result and a write-enable for the register file. The result is combinational. The next condition flags are captured in a register on each clock edge where the valid strobe is high.

Every operation that adds or subtracts uses a single adder with a carry input. Subtract, reverse subtract and their carry-chained forms are built by inverting one operand and choosing the carry input, so carry and overflow always come from that one adder. When the first operand is the program counter, it is read ahead of the current instruction. A flag-setting write to the program counter computes no flags. Instead it raises a request for the surrounding core to copy the saved status into the current status.

Top module: `dp_alu`

## Requirements
- R1: ADD (code 4) returns rn+op2 with carry-in 0, and ADC (code 5) returns rn+op2 with carry-in equal to flags_i bit 1. When flags are set, N is result bit 31 and Z is set for a zero result. C is set when the true unsigned sum needs more than 32 bits. V is set when the true signed sum of the sign-extended inputs differs from the sign-extended result. Flag bits are N=3, Z=2, C=1, V=0.
- R2: SUB (code 2) and SBC (code 6) compute rn + ~op2 with carry-in 1 and C respectively. RSB (code 3) and RSC (code 7) compute ~rn + op2 with carry-in 1 and C respectively. N, Z, C and V follow the rules of R1.
- R3: The compare and test codes are TST (8, AND), TEQ (9, XOR), CMP (10, like SUB) and CMN (11, like ADD). They never raise wr_en_o. With flags set, they update the flags exactly as the matching writing operation would.
- R4: AND (0), EOR (1), ORR (12), BIC (14, rn & ~op2), MOV (13, op2) and MVN (15, ~op2) write their result. With flags set, N and Z come from the result, C equals shift_carry_i, and V keeps flags_i bit 0.
- R5: MUL (16) returns the low 32 bits of rm*rs. MLA (17) returns the low 32 bits of rm*rs+rn, where rn is taken unadjusted. With flags set, only N and Z change, and C and V keep their flags_i values.
- R6: When rn_is_pc_i is high, every code from 0 to 15 uses rn_i+8 as its first operand. If pc_narrow_i is also high, it uses rn_i+4.
- R7: A valid operation with set_flags_i low loads flags_i unchanged into flags_o.
- R8: restore_req_o is high when a valid, writing operation has set_flags_i and rd_is_pc_i both high. In that case flags_o loads flags_i unchanged.
- R9: flags_o reads 0 during reset. It changes only on a clock edge where valid_i is high, and it holds its value otherwise.
- R10: Codes 18 to 31 are reserved. They raise neither wr_en_o nor restore_req_o, drive result_o to 0, and load flags_i unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Operation present this cycle |
| op_i | input | 5 | Operation code |
| rn_i | input | 32 | First operand register value |
| rn_is_pc_i | input | 1 | First operand register is the program counter |
| pc_narrow_i | input | 1 | 2-byte instruction mode |
| op2_i | input | 32 | Shifted second operand |
| shift_carry_i | input | 1 | Shifter carry-out |
| rm_i | input | 32 | Multiplicand |
| rs_i | input | 32 | Multiplier |
| set_flags_i | input | 1 | Operation requests flag update |
| rd_is_pc_i | input | 1 | Destination register is the program counter |
| flags_i | input | 4 | Current flags {N,Z,C,V} |
| result_o | output | 32 | Operation result |
| wr_en_o | output | 1 | Result to be written |
| restore_req_o | output | 1 | Copy saved status into current status |
| flags_o | output | 4 | Registered next flags {N,Z,C,V} |

## Verification
A wrong carry-in choice or a wrong inversion shows up at result_o in the same cycle as the operation. That makes such errors visible on the first subtract-family vector whose operands are not symmetric. A corrupted carry or overflow path shows only at flags_o, one clock edge after the strobe, and only for operand pairs that reach the 32-bit boundary. For that reason, directed vectors target the boundary values and random vectors cover every code. A flag register that loads when it should hold appears one edge later, as a flags_o that differs from the last flags_i supplied with a strobe.

// File: rtl/dpalu_pkg.sv
package dpalu_pkg;
  typedef enum logic [4:0] {
    OP_AND = 5'd0,  OP_EOR = 5'd1,  OP_SUB = 5'd2,  OP_RSB = 5'd3,
    OP_ADD = 5'd4,  OP_ADC = 5'd5,  OP_SBC = 5'd6,  OP_RSC = 5'd7,
    OP_TST = 5'd8,  OP_TEQ = 5'd9,  OP_CMP = 5'd10, OP_CMN = 5'd11,
    OP_ORR = 5'd12, OP_MOV = 5'd13, OP_BIC = 5'd14, OP_MVN = 5'd15,
    OP_MUL = 5'd16, OP_MLA = 5'd17
  } dp_op_e;

  typedef enum logic [1:0] {CLS_ARITH, CLS_LOGIC, CLS_MUL, CLS_NONE} op_class_e;

  localparam int FLAG_N = 3;
  localparam int FLAG_Z = 2;
  localparam int FLAG_C = 1;
  localparam int FLAG_V = 0;

  function automatic op_class_e op_class(input logic [4:0] op);
    case (op)
      OP_SUB, OP_RSB, OP_ADD, OP_ADC, OP_SBC, OP_RSC, OP_CMP, OP_CMN: return CLS_ARITH;
      OP_AND, OP_EOR, OP_TST, OP_TEQ, OP_ORR, OP_MOV, OP_BIC, OP_MVN: return CLS_LOGIC;
      OP_MUL, OP_MLA:                                                 return CLS_MUL;
      default:                                                        return CLS_NONE;
    endcase
  endfunction

  function automatic logic op_is_test(input logic [4:0] op);
    return (op == OP_TST) || (op == OP_TEQ) || (op == OP_CMP) || (op == OP_CMN);
  endfunction
endpackage

// File: rtl/dpalu_rst_sync.sv
module dpalu_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/dpalu_operand.sv
module dpalu_operand
  import dpalu_pkg::*;
#(
  parameter int W       = 32,
  parameter int PC_STEP = 4
) (
  input  logic [4:0]   op,
  input  logic [W-1:0] rn,
  input  logic         rn_is_pc,
  input  logic         pc_narrow,
  input  logic [W-1:0] op2,
  input  logic         c_flag,
  output logic [W-1:0] rn_eff,
  output logic [W-1:0] add_a,
  output logic [W-1:0] add_b,
  output logic         add_cin
);
  localparam logic [W-1:0] OFS_WIDE   = W'(2 * PC_STEP);
  localparam logic [W-1:0] OFS_NARROW = W'(PC_STEP);

  logic [W-1:0] pc_ofs;

  always_comb begin
    if (!rn_is_pc)      pc_ofs = '0;
    else if (pc_narrow) pc_ofs = OFS_NARROW;
    else                pc_ofs = OFS_WIDE;
    rn_eff = rn + pc_ofs;
  end

  always_comb begin
    add_a   = rn_eff;
    add_b   = op2;
    add_cin = 1'b0;
    case (op)
      OP_ADD, OP_CMN: add_cin = 1'b0;
      OP_ADC:         add_cin = c_flag;
      OP_SUB, OP_CMP: begin add_b = ~op2;    add_cin = 1'b1;   end
      OP_SBC:         begin add_b = ~op2;    add_cin = c_flag; end
      OP_RSB:         begin add_a = ~rn_eff; add_cin = 1'b1;   end
      OP_RSC:         begin add_a = ~rn_eff; add_cin = c_flag; end
      default: ;
    endcase
  end
endmodule

// File: rtl/dpalu_adder.sv
module dpalu_adder #(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cout,
  output logic         ovf
);
  logic [W:0] wide;

  always_comb begin
    wide = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin};
    sum  = wide[W-1:0];
    cout = wide[W];
    ovf  = (a[W-1] == b[W-1]) && (sum[W-1] != a[W-1]);
  end
endmodule

// File: rtl/dpalu_logic.sv
module dpalu_logic
  import dpalu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [4:0]   op,
  input  logic [W-1:0] rn_eff,
  input  logic [W-1:0] rn_raw,
  input  logic [W-1:0] op2,
  input  logic [W-1:0] rm,
  input  logic [W-1:0] rs,
  output logic [W-1:0] logic_res,
  output logic [W-1:0] mul_res
);
  logic [W-1:0] prod;

  always_comb begin
    case (op)
      OP_AND, OP_TST: logic_res = rn_eff & op2;
      OP_EOR, OP_TEQ: logic_res = rn_eff ^ op2;
      OP_ORR:         logic_res = rn_eff | op2;
      OP_BIC:         logic_res = rn_eff & ~op2;
      OP_MOV:         logic_res = op2;
      OP_MVN:         logic_res = ~op2;
      default:        logic_res = '0;
    endcase
  end

  always_comb begin
    prod    = rm * rs;
    mul_res = (op == OP_MLA) ? prod + rn_raw : prod;
  end
endmodule

// File: rtl/dp_alu.sv
module dp_alu
  import dpalu_pkg::*;
#(
  parameter int W       = 32,
  parameter int PC_STEP = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         valid_i,
  input  logic [4:0]   op_i,
  input  logic [W-1:0] rn_i,
  input  logic         rn_is_pc_i,
  input  logic         pc_narrow_i,
  input  logic [W-1:0] op2_i,
  input  logic         shift_carry_i,
  input  logic [W-1:0] rm_i,
  input  logic [W-1:0] rs_i,
  input  logic         set_flags_i,
  input  logic         rd_is_pc_i,
  input  logic [3:0]   flags_i,
  output logic [W-1:0] result_o,
  output logic         wr_en_o,
  output logic         restore_req_o,
  output logic [3:0]   flags_o
);
  logic         rst_sync_n;
  logic [W-1:0] rn_eff, add_a, add_b, sum, logic_res, mul_res;
  logic         add_cin, cout, ovf;
  op_class_e    cls;
  logic         writes, flag_upd, flags_en;
  logic [3:0]   flags_nx, flags_q;

  dpalu_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  dpalu_operand #(.W(W), .PC_STEP(PC_STEP)) u_opnd (
    .op(op_i), .rn(rn_i), .rn_is_pc(rn_is_pc_i), .pc_narrow(pc_narrow_i),
    .op2(op2_i), .c_flag(flags_i[FLAG_C]), .rn_eff(rn_eff),
    .add_a(add_a), .add_b(add_b), .add_cin(add_cin)
  );

  dpalu_adder #(.W(W)) u_add (
    .a(add_a), .b(add_b), .cin(add_cin), .sum(sum), .cout(cout), .ovf(ovf)
  );

  dpalu_logic #(.W(W)) u_log (
    .op(op_i), .rn_eff(rn_eff), .rn_raw(rn_i), .op2(op2_i),
    .rm(rm_i), .rs(rs_i), .logic_res(logic_res), .mul_res(mul_res)
  );

  always_comb begin
    cls    = op_class(op_i);
    writes = (cls != CLS_NONE) && !op_is_test(op_i);
    case (cls)
      CLS_ARITH: result_o = sum;
      CLS_LOGIC: result_o = logic_res;
      CLS_MUL:   result_o = mul_res;
      default:   result_o = '0;
    endcase
    wr_en_o       = valid_i && writes;
    restore_req_o = valid_i && writes && set_flags_i && rd_is_pc_i;
    flag_upd      = valid_i && set_flags_i && !restore_req_o && (cls != CLS_NONE);
  end

  // next-state for the flag register
  always_comb begin
    flags_nx = flags_i;
    if (flag_upd) begin
      flags_nx[FLAG_N] = result_o[W-1];
      flags_nx[FLAG_Z] = (result_o == '0);
      case (cls)
        CLS_ARITH: begin
          flags_nx[FLAG_C] = cout;
          flags_nx[FLAG_V] = ovf;
        end
        CLS_LOGIC: flags_nx[FLAG_C] = shift_carry_i;
        default: ;
      endcase
    end
    flags_en = valid_i;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)   flags_q <= '0;
    else if (flags_en) flags_q <= flags_nx;
  end

  assign flags_o = flags_q;
endmodule

// File: rtl/dp_alu_checker.sv
module dp_alu_checker #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         valid_i,
  input logic [4:0]   op_i,
  input logic         set_flags_i,
  input logic         rd_is_pc_i,
  input logic [3:0]   flags_i,
  input logic [W-1:0] result_o,
  input logic         wr_en_o,
  input logic         restore_req_o,
  input logic [3:0]   flags_o
);
  a_r3_test_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && op_i >= 5'd8 && op_i <= 5'd11) |-> !wr_en_o);

  a_r9_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_i |=> $stable(flags_o));

  a_r7_no_set_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && !set_flags_i) |=> (flags_o == $past(flags_i)));

  a_r8_restore_cause: assert property (@(posedge clk) disable iff (!rst_n)
    restore_req_o |-> (wr_en_o && set_flags_i && rd_is_pc_i));

  a_r8_restore_hold: assert property (@(posedge clk) disable iff (!rst_n)
    restore_req_o |=> (flags_o == $past(flags_i)));

  a_r1_nz_from_result: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && set_flags_i && !restore_req_o && op_i <= 5'd17)
      |=> (flags_o[2] == ($past(result_o) == '0)) && (flags_o[3] == $past(result_o[W-1])));

  a_r4_v_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && set_flags_i && !restore_req_o &&
     (op_i <= 5'd1 || (op_i >= 5'd12 && op_i <= 5'd15)))
      |=> (flags_o[0] == $past(flags_i[0])));

  a_r5_mul_cv_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && (op_i == 5'd16 || op_i == 5'd17)) |=> (flags_o[1:0] == $past(flags_i[1:0])));

  a_r10_reserved_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && op_i > 5'd17) |-> (!wr_en_o && !restore_req_o && result_o == '0));
endmodule

bind dp_alu dp_alu_checker #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .valid_i(valid_i), .op_i(op_i),
  .set_flags_i(set_flags_i), .rd_is_pc_i(rd_is_pc_i), .flags_i(flags_i),
  .result_o(result_o), .wr_en_o(wr_en_o), .restore_req_o(restore_req_o),
  .flags_o(flags_o)
);

// File: tb/dp_alu_bench.sv
module dp_alu_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        valid_i, rn_is_pc_i, pc_narrow_i, shift_carry_i, set_flags_i, rd_is_pc_i;
  logic [4:0]  op_i;
  logic [31:0] rn_i, op2_i, rm_i, rs_i, result_o;
  logic [3:0]  flags_i, flags_o;
  logic        wr_en_o, restore_req_o;

  int errors = 0;
  int checks = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  dp_alu u_dp_alu (
    .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .op_i(op_i), .rn_i(rn_i),
    .rn_is_pc_i(rn_is_pc_i), .pc_narrow_i(pc_narrow_i), .op2_i(op2_i),
    .shift_carry_i(shift_carry_i), .rm_i(rm_i), .rs_i(rs_i),
    .set_flags_i(set_flags_i), .rd_is_pc_i(rd_is_pc_i), .flags_i(flags_i),
    .result_o(result_o), .wr_en_o(wr_en_o), .restore_req_o(restore_req_o),
    .flags_o(flags_o)
  );

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // behavioural reference: true-width sums, no structure of the design
  task automatic model(input int op, input logic [31:0] rn, input logic rnpc, input logic narrow,
                       input logic [31:0] op2, input logic sc, input logic [31:0] rm, input logic [31:0] rs,
                       input logic set, input logic rdpc, input logic [3:0] fl,
                       output logic [31:0] res, output logic wr, output logic rq, output logic [3:0] nf);
    logic [31:0] rv, a, b;
    logic [63:0] us;
    longint      ss;
    int          ci;
    int          kind; // 0 arith 1 logic 2 mul 3 none
    bit          test;
    rv = rn + (rnpc ? (narrow ? 32'd4 : 32'd8) : 32'd0);
    a = rv; b = op2; ci = 0; kind = 3; res = 0;
    test = (op >= 8 && op <= 11);
    case (op)
      4, 11: begin kind = 0; end
      5:     begin kind = 0; ci = int'(fl[1]); end
      2, 10: begin kind = 0; b = ~op2; ci = 1; end
      6:     begin kind = 0; b = ~op2; ci = int'(fl[1]); end
      3:     begin kind = 0; a = ~rv; ci = 1; end
      7:     begin kind = 0; a = ~rv; ci = int'(fl[1]); end
      0, 8:  begin kind = 1; res = rv & op2; end
      1, 9:  begin kind = 1; res = rv ^ op2; end
      12:    begin kind = 1; res = rv | op2; end
      13:    begin kind = 1; res = op2; end
      14:    begin kind = 1; res = rv & ~op2; end
      15:    begin kind = 1; res = ~op2; end
      16:    begin kind = 2; res = 32'(64'(rm) * 64'(rs)); end
      17:    begin kind = 2; res = 32'(64'(rm) * 64'(rs) + 64'(rn)); end
      default: kind = 3;
    endcase
    nf = fl;
    us = 64'(a) + 64'(b) + 64'(ci);
    ss = longint'($signed(a)) + longint'($signed(b)) + longint'(ci);
    if (kind == 0) res = us[31:0];
    wr = (kind != 3) && !test;
    rq = wr && set && rdpc;
    if (set && !rq && kind != 3) begin
      nf[3] = res[31];
      nf[2] = (res == 0);
      if (kind == 0) begin
        nf[1] = (us > 64'hFFFF_FFFF);
        nf[0] = (longint'($signed(res)) != ss);
      end else if (kind == 1) nf[1] = sc;
    end
  endtask

  function automatic string tag_for(input int op, input logic rnpc, input logic rdpc, input logic set);
    if (op > 17) return "R10";
    if (set && rdpc && !(op >= 8 && op <= 11)) return "R8";
    if (!set) return "R7";
    if (rnpc && op < 16) return "R6";
    if (op >= 8 && op <= 11) return "R3";
    if (op >= 16) return "R5";
    if (op == 4 || op == 5) return "R1";
    if (op == 2 || op == 3 || op == 6 || op == 7) return "R2";
    return "R4";
  endfunction

  task automatic run(input int op, input logic [31:0] rn, input logic rnpc, input logic narrow,
                     input logic [31:0] op2, input logic sc, input logic [31:0] rm, input logic [31:0] rs,
                     input logic set, input logic rdpc, input logic [3:0] fl);
    logic [31:0] er; logic ew, eq; logic [3:0] ef;
    string t;
    @(negedge clk);
    valid_i = 1; op_i = 5'(op); rn_i = rn; rn_is_pc_i = rnpc; pc_narrow_i = narrow;
    op2_i = op2; shift_carry_i = sc; rm_i = rm; rs_i = rs; set_flags_i = set;
    rd_is_pc_i = rdpc; flags_i = fl;
    model(op, rn, rnpc, narrow, op2, sc, rm, rs, set, rdpc, fl, er, ew, eq, ef);
    t = tag_for(op, rnpc, rdpc, set);
    #1;
    check(t, $sformatf("result op%0d", op), result_o, er);
    check(t, "wr_en", 32'(wr_en_o), 32'(ew));
    check(t, "restore_req", 32'(restore_req_o), 32'(eq));
    @(posedge clk); #1;
    check(t, $sformatf("flags op%0d", op), 32'(flags_o), 32'(ef));
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [3:0] hold;
    rst_n = 0; valid_i = 0; op_i = 0; rn_i = 0; rn_is_pc_i = 0; pc_narrow_i = 0;
    op2_i = 0; shift_carry_i = 0; rm_i = 0; rs_i = 0; set_flags_i = 0;
    rd_is_pc_i = 0; flags_i = 4'hF;
    repeat (3) @(posedge clk);
    #1 check("R9", "flags in reset", 32'(flags_o), 32'h0);
    @(negedge clk) rst_n = 1;
    repeat (4) @(posedge clk);
    #1 check("R9", "flags after reset idle", 32'(flags_o), 32'h0);

    // R1 boundaries
    run(4, 32'hFFFF_FFFF, 0, 0, 32'h1, 0, 0, 0, 1, 0, 4'h0);
    run(4, 32'h7FFF_FFFF, 0, 0, 32'h1, 0, 0, 0, 1, 0, 4'h0);
    run(5, 32'h7FFF_FFFE, 0, 0, 32'h1, 0, 0, 0, 1, 0, 4'h2);
    run(5, 32'h8000_0000, 0, 0, 32'h7FFF_FFFF, 0, 0, 0, 1, 0, 4'h2);
    // R2 subtract family
    run(2, 32'h5, 0, 0, 32'h5, 0, 0, 0, 1, 0, 4'h0);
    run(2, 32'h0, 0, 0, 32'h1, 0, 0, 0, 1, 0, 4'h0);
    run(6, 32'h5, 0, 0, 32'h5, 0, 0, 0, 1, 0, 4'h0);
    run(3, 32'h3, 0, 0, 32'h10, 0, 0, 0, 1, 0, 4'h0);
    run(7, 32'h3, 0, 0, 32'h10, 0, 0, 0, 1, 0, 4'h0);
    run(2, 32'h8000_0000, 0, 0, 32'h1, 0, 0, 0, 1, 0, 4'h0);
    // R3 compare/test
    run(10, 32'h9, 0, 0, 32'h9, 0, 0, 0, 1, 0, 4'h0);
    run(11, 32'hFFFF_FFFF, 0, 0, 32'h1, 0, 0, 0, 1, 1, 4'h0);
    run(8, 32'hF0, 0, 0, 32'h0F, 1, 0, 0, 1, 0, 4'h1);
    run(9, 32'h8000_0000, 0, 0, 32'h0, 0, 0, 0, 1, 0, 4'h3);
    // R4 logic with shifter carry and V kept
    run(14, 32'hFF, 0, 0, 32'hFF, 1, 0, 0, 1, 0, 4'h1);
    run(15, 32'h0, 0, 0, 32'h0, 0, 0, 0, 1, 0, 4'h3);
    // R5 multiply
    run(16, 0, 0, 0, 0, 0, 32'h1_0000, 32'h1_0000, 1, 0, 4'h3);
    run(17, 32'h5, 0, 0, 0, 0, 32'hFFFF_FFFF, 32'h2, 1, 0, 4'h0);
    // R6 pc operand
    run(4, 32'h1000, 1, 0, 32'h0, 0, 0, 0, 1, 0, 4'h0);
    run(4, 32'h1000, 1, 1, 32'h0, 0, 0, 0, 1, 0, 4'h0);
    run(17, 32'h1000, 1, 0, 0, 0, 32'h2, 32'h3, 1, 0, 4'h0);
    // R7, R8, R10
    run(4, 32'hFFFF_FFFF, 0, 0, 32'h1, 0, 0, 0, 0, 0, 4'hA);
    run(2, 32'h1, 0, 0, 32'h1, 0, 0, 0, 1, 1, 4'h5);
    run(20, 32'h1, 0, 0, 32'h1, 0, 0, 0, 1, 1, 4'h9);
    // R9 idle hold
    @(negedge clk);
    hold = flags_o; valid_i = 0; flags_i = ~hold; op_i = 5'd4; set_flags_i = 1;
    @(posedge clk); #1;
    check("R9", "flags hold with valid low", 32'(flags_o), 32'(hold));
    check("R9", "no write with valid low", 32'(wr_en_o), 32'h0);

    for (int i = 0; i < 600; i++) begin
      run($urandom_range(0, 19), $urandom(), ($urandom_range(0, 7) == 0), $urandom_range(0, 1),
          ($urandom_range(0, 3) == 0) ? 32'hFFFF_FFFF : $urandom(), $urandom_range(0, 1),
          $urandom(), $urandom(), ($urandom_range(0, 3) != 0), ($urandom_range(0, 7) == 0),
          4'($urandom_range(0, 15)));
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule